// File: doc/BRIEF.md
# Sticky Link Event Interrupt Register

This block collects event sources around a display-link transmitter core and keeps a record of them in two 8-bit interrupt flag registers. The sources are the hot-plug line, the receiver-sense comparator output, the video sync input, the link controller's 4-bit state code, and three single-cycle pulses from that controller: EDID capture done, downstream key list ready, and controller error. Each source has its own detection rule. Hot-plug and receiver-sense flag on any transition. Sync flags on a rising edge only. The state code flags only on the step from 3 (initializing HDCP) to 4 (HDCP enabled). The controller pulses flag directly.

The three line inputs may be asynchronous, so each passes through a two-stage synchronizer before its edge detector. A flag stays at 1 until software writes a 0 to its bit position. Writing 1 leaves it unchanged. Two enable registers mask the flags onto one registered interrupt output. A read-only status register shows the controller state code and the synchronized hot-plug and receiver-sense levels. The state code values are 0 = no hot plug, 1 = reading EDID, 2 = idle awaiting an HDCP request, 3 = initializing HDCP, 4 = HDCP enabled, and 5 = initializing repeater.

Top module: `link_evt_irq`

## Requirements
- R1: A rising or a falling transition of `hpd_in` sets flag register A (address 0) bit 7.
- R2: A rising or a falling transition of `rxsense_in` sets flag register A bit 6.
- R3: A rising edge of `vsync_in` sets flag register A bit 5. A falling edge sets nothing.
- R4: Flag A bit 1 sets when `ctl_state` goes from 3 in one cycle to 4 in the next. Every other step, including 2 to 4 and 4 to 3, leaves it unchanged.
- R5: A high cycle on `edid_done` sets flag A bit 2. A high cycle on `ksv_ready` sets flag register B (address 1) bit 6. A high cycle on `ctl_error` sets flag B bit 7.
- R6: A set flag stays at 1 until a write of 0 to its bit. A write of 1 to a flag bit has no effect.
- R7: When an event and a write of 0 to the same flag fall in the same cycle, the flag ends up set.
- R8: Unused flag bits always read 0. Register A uses bits 7, 6, 5, 2 and 1. Register B uses bits 7 and 6.
- R9: The enable registers (A at address 2, B at address 3) are 8-bit read/write. `irq` is high one cycle after any flag is set with its matching enable bit at 1. `irq` is low when no such pair exists.
- R10: The status register at address 4 reads the current `ctl_state` in bits [3:0], the synchronized hot-plug level in bit 4 and the synchronized receiver-sense level in bit 5. Its other bits read 0.
- R11: `reg_rdata` returns the register at `reg_addr` one clock after the address is presented. Addresses 5 to 7 read 0. After reset every register and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| hpd_in | input | 1 | Hot-plug line, asynchronous |
| rxsense_in | input | 1 | Receiver-sense comparator output, asynchronous |
| vsync_in | input | 1 | Video sync input, asynchronous |
| ctl_state | input | 4 | Link controller state code |
| edid_done | input | 1 | EDID captured pulse |
| ksv_ready | input | 1 | Downstream key list ready pulse |
| ctl_error | input | 1 | Controller error pulse |
| irq | output | 1 | Combined masked interrupt, registered |

## Verification
The hardest case to reach is an event landing in the same clock as a software clear of the same flag. The bench times this by raising `edid_done` in the very cycle that a zero is written to register A. It then reads the register back and expects the flag to be set. The 3-to-4 rule is tested against the near cases, 2 to 4 and 4 to 3, with reads after each step. The sync input is taken low as well as high, so that a flag set on the falling edge would show up.

// File: rtl/link_evt_pkg.sv
package link_evt_pkg;
  localparam int REG_W = 8;

  localparam logic [2:0] ADR_FLAG_A = 3'd0;
  localparam logic [2:0] ADR_FLAG_B = 3'd1;
  localparam logic [2:0] ADR_EN_A   = 3'd2;
  localparam logic [2:0] ADR_EN_B   = 3'd3;
  localparam logic [2:0] ADR_LIVE   = 3'd4;

  localparam int A_STEP  = 1;
  localparam int A_EDID  = 2;
  localparam int A_VSYNC = 5;
  localparam int A_RXS   = 6;
  localparam int A_HPD   = 7;
  localparam int B_KSV   = 6;
  localparam int B_ERR   = 7;

  localparam logic [REG_W-1:0] MASK_A = 8'hE6;
  localparam logic [REG_W-1:0] MASK_B = 8'hC0;

  localparam logic [3:0] ST_HDCP_INIT = 4'd3;
  localparam logic [3:0] ST_HDCP_ON   = 4'd4;

  localparam int N_LINES = 3;
  localparam int LN_HPD = 0;
  localparam int LN_RXS = 1;
  localparam int LN_VS  = 2;
endpackage

// File: rtl/link_evt_edge.sv
module link_evt_edge #(
  parameter int STAGES   = 2,
  parameter bit ANY_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o,
  output logic evt_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign level_o = chain[STAGES-1];

  generate
    if (ANY_EDGE) begin : g_any
      assign evt_o = chain[STAGES-1] ^ chain[STAGES];
    end else begin : g_rise
      assign evt_o = chain[STAGES-1] & ~chain[STAGES];
    end
  endgenerate
endmodule

// File: rtl/link_evt_sticky.sv
module link_evt_sticky #(
  parameter int W = 8,
  parameter logic [W-1:0] USED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         wr_sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags_q
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] flags_d;

  always_comb begin
    clr_vec = wr_sel ? ~wdata : '0;
    flags_d = ((flags_q & ~clr_vec) | set_vec) & USED;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ((set_vec & USED) != '0) |=> ((flags_q & $past(set_vec & USED)) == $past(set_vec & USED))); // R7

  AST_CLEAR_ZEROS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && set_vec == '0) |=> (flags_q == ($past(flags_q) & $past(wdata)))); // R6
endmodule

// File: rtl/link_evt_irq.sv
module link_evt_irq
  import link_evt_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int ST_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              hpd_in,
  input  logic              rxsense_in,
  input  logic              vsync_in,
  input  logic [ST_W-1:0]   ctl_state,
  input  logic              edid_done,
  input  logic              ksv_ready,
  input  logic              ctl_error,
  output logic              irq
);
  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] line_lvl;
  logic [N_LINES-1:0] line_evt;

  assign raw_lines[LN_HPD] = hpd_in;
  assign raw_lines[LN_RXS] = rxsense_in;
  assign raw_lines[LN_VS]  = vsync_in;

  genvar gi;
  generate
    for (gi = 0; gi < N_LINES; gi++) begin : g_line
      link_evt_edge #(
        .STAGES  (SYNC_STAGES),
        .ANY_EDGE(gi != LN_VS)
      ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .din    (raw_lines[gi]),
        .level_o(line_lvl[gi]),
        .evt_o  (line_evt[gi])
      );
    end
  endgenerate

  logic [ST_W-1:0] state_q;
  logic            step_evt;

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= ctl_state;
  end

  assign step_evt = (state_q == ST_W'(ST_HDCP_INIT)) && (ctl_state == ST_W'(ST_HDCP_ON));

  logic [REG_W-1:0] set_a, set_b;
  always_comb begin
    set_a          = '0;
    set_a[A_HPD]   = line_evt[LN_HPD];
    set_a[A_RXS]   = line_evt[LN_RXS];
    set_a[A_VSYNC] = line_evt[LN_VS];
    set_a[A_EDID]  = edid_done;
    set_a[A_STEP]  = step_evt;
    set_b          = '0;
    set_b[B_KSV]   = ksv_ready;
    set_b[B_ERR]   = ctl_error;
  end

  logic wr_a, wr_b;
  assign wr_a = reg_wr && (reg_addr == ADDR_W'(ADR_FLAG_A));
  assign wr_b = reg_wr && (reg_addr == ADDR_W'(ADR_FLAG_B));

  logic [REG_W-1:0] flags_a, flags_b;

  link_evt_sticky #(.W(REG_W), .USED(MASK_A)) u_flags_a (
    .clk(clk), .rst(rst), .set_vec(set_a), .wr_sel(wr_a),
    .wdata(reg_wdata), .flags_q(flags_a)
  );

  link_evt_sticky #(.W(REG_W), .USED(MASK_B)) u_flags_b (
    .clk(clk), .rst(rst), .set_vec(set_b), .wr_sel(wr_b),
    .wdata(reg_wdata), .flags_q(flags_b)
  );

  logic [REG_W-1:0] en_a, en_b;
  always_ff @(posedge clk) begin
    if (rst) begin
      en_a <= '0;
      en_b <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(ADR_EN_A)) en_a <= reg_wdata;
      if (reg_addr == ADDR_W'(ADR_EN_B)) en_b <= reg_wdata;
    end
  end

  logic [REG_W-1:0] live_word;
  always_comb begin
    live_word         = '0;
    live_word[3:0]    = ctl_state[3:0];
    live_word[4]      = line_lvl[LN_HPD];
    live_word[5]      = line_lvl[LN_RXS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_W'(ADR_FLAG_A): reg_rdata <= flags_a;
        ADDR_W'(ADR_FLAG_B): reg_rdata <= flags_b;
        ADDR_W'(ADR_EN_A):   reg_rdata <= en_a;
        ADDR_W'(ADR_EN_B):   reg_rdata <= en_b;
        ADDR_W'(ADR_LIVE):   reg_rdata <= live_word;
        default:             reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags_a & en_a) | |(flags_b & en_b);
  end

  AST_STEP_ONLY_3_TO_4: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_a[A_STEP]) |-> ($past(ctl_state) == ST_W'(ST_HDCP_ON) &&
                                $past(ctl_state, 2) == ST_W'(ST_HDCP_INIT))); // R4

  AST_IRQ_LOW_WHEN_MASKED: assert property (@(posedge clk) disable iff (rst)
    (en_a == '0 && en_b == '0 && $past(en_a) == '0 && $past(en_b) == '0) |-> !irq); // R9

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == ADDR_W'(ADR_FLAG_A) && !$past(rst)) |-> ((reg_rdata & ~MASK_A) == '0)); // R8
endmodule

// File: tb/link_evt_irq_bench.sv
module link_evt_irq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       hpd_in = 1'b0, rxsense_in = 1'b0, vsync_in = 1'b0;
  logic [3:0] ctl_state = '0;
  logic       edid_done = 1'b0, ksv_ready = 1'b0, ctl_error = 1'b0;
  logic       irq;

  always #5 clk = ~clk;

  link_evt_irq u_link_evt_irq (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hpd_in(hpd_in),
    .rxsense_in(rxsense_in), .vsync_in(vsync_in), .ctl_state(ctl_state),
    .edid_done(edid_done), .ksv_ready(ksv_ready), .ctl_error(ctl_error),
    .irq(irq)
  );

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    int         due;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items once they fall due and compares
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = exp_q.pop_front();
      act = it.is_irq ? {7'd0, irq} : reg_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: %s actual=%02h expected=%02h", it.tag,
                 it.is_irq ? "irq" : "rdata", act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.is_irq = 0; it.exp = e; it.due = cyc + 1; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1; it.exp = {7'd0, e}; it.due = cyc + 1; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: R11 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    // R11 reset state
    rd(3'd0, 8'h00, "R11"); rd(3'd1, 8'h00, "R11"); rd(3'd2, 8'h00, "R11");
    rd(3'd3, 8'h00, "R11"); rd(3'd4, 8'h00, "R11"); chk_irq(1'b0, "R11");

    // R1 hot-plug both edges
    @(negedge clk) hpd_in = 1'b1; tick(4);
    rd(3'd0, 8'h80, "R1");
    rd(3'd4, 8'h10, "R10");
    wr(3'd0, 8'h7F); rd(3'd0, 8'h00, "R6");
    @(negedge clk) hpd_in = 1'b0; tick(4);
    rd(3'd0, 8'h80, "R1");
    wr(3'd0, 8'hFF); rd(3'd0, 8'h80, "R6");      // writing 1 keeps it
    wr(3'd0, 8'h00); rd(3'd0, 8'h00, "R6");

    // R2 receiver sense both edges
    @(negedge clk) rxsense_in = 1'b1; tick(4);
    rd(3'd0, 8'h40, "R2"); rd(3'd4, 8'h20, "R10");
    wr(3'd0, 8'h00);
    @(negedge clk) rxsense_in = 1'b0; tick(4);
    rd(3'd0, 8'h40, "R2"); wr(3'd0, 8'h00);

    // R3 sync rising only
    @(negedge clk) vsync_in = 1'b1; tick(4);
    rd(3'd0, 8'h20, "R3"); wr(3'd0, 8'h00);
    @(negedge clk) vsync_in = 1'b0; tick(4);
    rd(3'd0, 8'h00, "R3");

    // R4 state step rule
    @(negedge clk) ctl_state = 4'd2; tick(2);
    @(negedge clk) ctl_state = 4'd4; tick(2);
    rd(3'd0, 8'h00, "R4");
    @(negedge clk) ctl_state = 4'd3; tick(2);
    rd(3'd0, 8'h00, "R4");
    rd(3'd4, 8'h03, "R10");
    @(negedge clk) ctl_state = 4'd4; tick(2);
    rd(3'd0, 8'h02, "R4");
    wr(3'd0, 8'h00);
    @(negedge clk) ctl_state = 4'd3; tick(2);
    rd(3'd0, 8'h00, "R4");
    @(negedge clk) ctl_state = 4'd5; tick(2);
    rd(3'd4, 8'h05, "R10");

    // R5 controller pulses
    pulse(edid_done); tick(1); rd(3'd0, 8'h04, "R5");
    pulse(ksv_ready); tick(1); rd(3'd1, 8'h40, "R5");
    pulse(ctl_error); tick(1); rd(3'd1, 8'hC0, "R5");
    wr(3'd1, 8'h7F); rd(3'd1, 8'h40, "R6");

    // R8 unused bits stay zero
    @(negedge clk) hpd_in = 1'b1; rxsense_in = 1'b1; vsync_in = 1'b1; tick(4);
    @(negedge clk) ctl_state = 4'd3; tick(1);
    @(negedge clk) ctl_state = 4'd4; tick(2);
    wr(3'd1, 8'hFF);
    rd(3'd0, 8'hE6, "R8"); rd(3'd1, 8'h40, "R8");
    rd(3'd5, 8'h00, "R11"); rd(3'd7, 8'h00, "R11");

    // R9 interrupt masking
    chk_irq(1'b0, "R9");
    wr(3'd2, 8'h80); tick(2);
    rd(3'd2, 8'h80, "R9"); chk_irq(1'b1, "R9");
    wr(3'd2, 8'h00); tick(2); chk_irq(1'b0, "R9");
    wr(3'd3, 8'h40); tick(2); rd(3'd3, 8'h40, "R9"); chk_irq(1'b1, "R9");
    wr(3'd1, 8'h00); tick(2); chk_irq(1'b0, "R9");
    wr(3'd3, 8'h00);

    // R7 set beats clear in the same cycle
    wr(3'd0, 8'h00); rd(3'd0, 8'h00, "R7");
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 8'h00; reg_wr = 1'b1; edid_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; edid_done = 1'b0;
    rd(3'd0, 8'h04, "R7");

    tick(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule